// File: doc/BRIEF.md
# Power Management Event and SCI Unit

This block holds the event side of an ACPI-style power-management register set: a status word, an enable word, a control word and a free-running timer. Software reaches it through a 64-byte I/O window. The host configuration logic supplies the window's location and its enable. The block raises a level-sensitive system-control interrupt (SCI) while any enabled event is pending. Software clears a pending event by writing a one to its status bit.

Four event sources exist: timer overflow, a global-lock request, the power button and the RTC alarm. Each of the last three arrives as a single-cycle pulse. The timer is a TMR_W-bit up-counter (24 by default) that advances on each cycle in which `tick_en` is high. Its status bit is set each time the counter's top bit changes value.

Reads use a small two-state responder. From `ST_IDLE`, a read that hits the window takes the transition `RD_ACCEPT` to `ST_RESP`. In `ST_RESP`, `rd_valid` is high and the data captured in the read cycle is presented. A further read hit takes `RD_CHAIN` and stays in `ST_RESP`. Any other cycle takes `RD_DONE` back to `ST_IDLE`. Writes complete in the cycle they are presented.

Top module: `pm_sci_unit`

## Requirements
- R1: After reset the status, enable, control and timer registers are zero, `sci` is low and `rd_valid` is low.
- R2: An access hits only when `cfg_win_en` is 1 and `io_addr[15:6]` equals `cfg_base_blk`. A read that misses produces no `rd_valid`, and a write that misses changes no register.
- R3: Changing `cfg_base_blk` moves the window. Register contents are kept, and the old addresses no longer respond.
- R4: The window offsets are status 0x00, enable 0x02, control 0x04 and timer 0x08. A read hit drives `rd_valid` high for one cycle, starting in the cycle after the read. `io_rdata` carries the register value as it was in the read cycle, zero-extended. Any other offset in the window reads as 0.
- R5: Writing to status clears each bit written as 1 and leaves each bit written as 0 unchanged. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R6: The enable register stores only bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC). Writing 0xFFFF reads back as 0x0521.
- R7: `sci` is high exactly when the status and enable registers share a set bit among bits 0, 5, 8 and 10. It follows each register update in the next cycle.
- R8: A one-cycle pulse on `pwrbtn_evt`, `rtc_evt` or `gbl_req` sets status bit 8, 10 or 5 respectively.
- R9: The timer advances by one on each cycle in which `tick_en` is high and holds otherwise. Writes to offset 0x08 are ignored.
- R10: Status bit 0 is set whenever the timer's top bit toggles, on the change from 0 to 1 and on the change from 1 to 0.
- R11: The control register at 0x04 is a 16-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_blk | input | ADDR_W-6 (10) | Window base address bits 15:6, taken from the host configuration |
| cfg_win_en | input | 1 | Window decode enable from the host configuration |
| io_addr | input | ADDR_W (16) | I/O byte address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 16 | Write data |
| tick_en | input | 1 | Timer advance qualifier |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | RTC alarm event pulse |
| gbl_req | input | 1 | Global-lock request pulse |
| io_rdata | output | 32 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | Read response strobe |
| sci | output | 1 | System-control interrupt level |

## Verification
The SCI logic is exercised with each source set while its enable is clear and again while it is set. Enables for other sources are also set alone. This separates a correct AND-then-OR from an OR over status alone and from a wrong bit position. Status writes use a matching one, a non-matching one, all zeros, and a clear that coincides with a new event, which tells true write-one-to-clear apart from plain writes and from clear-wins priority. The timer is advanced to one tick short of its top-bit change, then to the change, then through the change in the other direction, which checks that both edges are detected and that nothing fires early. Window tests use the enable low, an address outside the window, and a moved base, which separates decode on the upper address bits from decode on the full address.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int REG_W = 16;
    localparam int RD_W  = 32;

    localparam int BIT_TMR = 0;
    localparam int BIT_GBL = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;

    localparam logic [REG_W-1:0] EVT_MASK =
        REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));

    localparam logic [7:0] OFF_STS = 8'h00;
    localparam logic [7:0] OFF_EN  = 8'h02;
    localparam logic [7:0] OFF_CNT = 8'h04;
    localparam logic [7:0] OFF_TMR = 8'h08;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_t;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 6
) (
    input  logic [ADDR_W-OFF_W-1:0] cfg_base_blk,
    input  logic                    cfg_win_en,
    input  logic [ADDR_W-1:0]       io_addr,
    output logic                    win_hit,
    output logic [OFF_W-1:0]        win_off
);
    always_comb begin
        win_hit = cfg_win_en && (io_addr[ADDR_W-1:OFF_W] == cfg_base_blk);
        win_off = io_addr[OFF_W-1:0];
    end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] tmr_q,
    output logic         top_flip
);
    always_comb top_flip = tick_en && (&tmr_q[W-2:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (tick_en) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic             wr_cnt,
    input  logic [REG_W-1:0] wdata,
    input  logic             set_tmr,
    input  logic             set_gbl,
    input  logic             set_pwr,
    input  logic             set_rtc,
    output logic [REG_W-1:0] sts_q,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] cnt_q,
    output logic             sci
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] sts_d;
    logic [REG_W-1:0] pend;

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_TMR] = set_tmr;
        set_vec[BIT_GBL] = set_gbl;
        set_vec[BIT_PWR] = set_pwr;
        set_vec[BIT_RTC] = set_rtc;
    end

    always_comb begin
        sts_d = sts_q;
        if (wr_sts) begin
            sts_d = sts_d & ~wdata;
        end
        sts_d = (sts_d | set_vec) & EVT_MASK;
    end

    genvar gi;
    generate
        for (gi = 0; gi < REG_W; gi++) begin : g_pend
            if (EVT_MASK[gi]) begin : g_src
                assign pend[gi] = sts_q[gi] & en_q[gi];
            end else begin : g_none
                assign pend[gi] = 1'b0;
            end
        end
    endgenerate

    always_comb sci = |pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            cnt_q <= '0;
        end else begin
            sts_q <= sts_d;
            if (wr_en) begin
                en_q <= wdata & EVT_MASK;
            end
            if (wr_cnt) begin
                cnt_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/pm_sci_unit.sv
module pm_sci_unit
    import pm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_BYTES = 64,
    parameter int TMR_W     = 24,
    localparam int OFF_W    = $clog2(WIN_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] cfg_base_blk,
    input  logic                    cfg_win_en,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_rd,
    input  logic                    io_wr,
    input  logic [REG_W-1:0]        io_wdata,
    input  logic                    tick_en,
    input  logic                    pwrbtn_evt,
    input  logic                    rtc_evt,
    input  logic                    gbl_req,
    output logic [RD_W-1:0]         io_rdata,
    output logic                    rd_valid,
    output logic                    sci
);
    logic             win_hit;
    logic [OFF_W-1:0] win_off;
    logic [7:0]       off8;
    logic             rd_hit;
    logic             wr_hit;
    logic [TMR_W-1:0] tmr_q;
    logic             top_flip;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] cnt_q;
    logic [RD_W-1:0]  rd_mux;
    logic [RD_W-1:0]  rdata_q;
    rsp_state_t       state_q;
    rsp_state_t       state_d;

    pm_win_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
        .cfg_base_blk (cfg_base_blk),
        .cfg_win_en   (cfg_win_en),
        .io_addr      (io_addr),
        .win_hit      (win_hit),
        .win_off      (win_off)
    );

    pm_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .tmr_q    (tmr_q),
        .top_flip (top_flip)
    );

    always_comb begin
        off8   = 8'(win_off);
        rd_hit = io_rd && win_hit;
        wr_hit = io_wr && win_hit;
    end

    pm_evt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sts  (wr_hit && (off8 == OFF_STS)),
        .wr_en   (wr_hit && (off8 == OFF_EN)),
        .wr_cnt  (wr_hit && (off8 == OFF_CNT)),
        .wdata   (io_wdata),
        .set_tmr (top_flip),
        .set_gbl (gbl_req),
        .set_pwr (pwrbtn_evt),
        .set_rtc (rtc_evt),
        .sts_q   (sts_q),
        .en_q    (en_q),
        .cnt_q   (cnt_q),
        .sci     (sci)
    );

    always_comb begin
        unique case (off8)
            OFF_STS: rd_mux = RD_W'(sts_q);
            OFF_EN:  rd_mux = RD_W'(en_q);
            OFF_CNT: rd_mux = RD_W'(cnt_q);
            OFF_TMR: rd_mux = RD_W'(tmr_q);
            default: rd_mux = '0;
        endcase
    end

    // Next-state logic of the read responder
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_hit)  state_d = ST_RESP;   // RD_ACCEPT
            ST_RESP: if (!rd_hit) state_d = ST_IDLE;   // RD_DONE, else RD_CHAIN
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_hit) begin
                rdata_q <= rd_mux;
            end
        end
    end

    // Outputs from the state
    always_comb begin
        unique case (state_q)
            ST_RESP: begin
                rd_valid = 1'b1;
                io_rdata = rdata_q;
            end
            default: begin
                rd_valid = 1'b0;
                io_rdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/pm_sci_chk.sv
module pm_sci_chk
    import pm_pkg::*;
#(
    parameter int TMR_W = 24,
    parameter int OFF_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_rd,
    input logic             io_wr,
    input logic [REG_W-1:0] io_wdata,
    input logic             win_hit,
    input logic [OFF_W-1:0] win_off,
    input logic             tick_en,
    input logic             pwrbtn_evt,
    input logic             rtc_evt,
    input logic [TMR_W-1:0] tmr_q,
    input logic [REG_W-1:0] sts_q,
    input logic             sci,
    input logic             rd_valid
);
    // R2
    a_r2_no_resp_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !win_hit) |=> !rd_valid);

    // R4
    a_r4_resp_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && win_hit) |=> rd_valid);

    // R5
    a_r5_w1c_rtc: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && win_hit && (8'(win_off) == OFF_STS) && io_wdata[BIT_RTC] && !rtc_evt)
        |=> !sts_q[BIT_RTC]);

    // R7
    a_r7_sci_drops_on_zero_en: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && win_hit && (8'(win_off) == OFF_EN) && (io_wdata == '0)) |=> !sci);

    // R8
    a_r8_pwrbtn_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn_evt |=> sts_q[BIT_PWR]);

    // R9
    a_r9_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tmr_q));

    // R10
    a_r10_flip_sets_sts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (&tmr_q[TMR_W-2:0])) |=> sts_q[BIT_TMR]);
endmodule

bind pm_sci_unit pm_sci_chk #(.TMR_W(TMR_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .win_hit    (win_hit),
    .win_off    (win_off),
    .tick_en    (tick_en),
    .pwrbtn_evt (pwrbtn_evt),
    .rtc_evt    (rtc_evt),
    .tmr_q      (tmr_q),
    .sts_q      (sts_q),
    .sci        (sci),
    .rd_valid   (rd_valid)
);

// File: tb/pm_sci_unit_tb.sv
module pm_sci_unit_tb;
    localparam int TW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cfg_base_blk = 10'h2C1;
    logic        cfg_win_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = '0;
    logic        tick_en = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        rtc_evt = 1'b0;
    logic        gbl_req = 1'b0;
    logic [31:0] io_rdata;
    logic        rd_valid;
    logic        sci;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    pm_sci_unit #(.TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base_blk(cfg_base_blk), .cfg_win_en(cfg_win_en),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .tick_en(tick_en), .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt), .gbl_req(gbl_req),
        .io_rdata(io_rdata), .rd_valid(rd_valid), .sci(sci)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R4: unexpected response actual %h expected none", io_rdata);
            end else begin
                check(tag_q.pop_front(), io_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_read(input logic [15:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        io_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_none(input logic [15:0] a, input string tag);
        @(posedge clk); #1;
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        io_rd = 1'b0;
        @(negedge clk);
        check(tag, 32'(rd_valid), 32'd0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic sci_is(input logic e, input string tag);
        @(negedge clk);
        check(tag, 32'(sci), 32'(e));
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 sci after reset", 32'(sci), 32'd0);
        check("R1 rd_valid after reset", 32'(rd_valid), 32'd0);

        read_none(16'hB040, "R2 read with window disabled");
        cfg_win_en = 1'b1;
        do_read(16'hB040, 32'h0, "R1 status reset");
        do_read(16'hB042, 32'h0, "R1 enable reset");
        do_read(16'hB044, 32'h0, "R1 control reset");
        do_read(16'hB048, 32'h0, "R1 timer reset");

        do_write(16'hB044, 16'hA5C3);
        do_read(16'hB044, 32'hA5C3, "R11 control readback");
        do_read(16'hB04C, 32'h0, "R4 unmapped offset");
        do_read(16'hB046, 32'h0, "R4 gap offset");

        do_write(16'hB042, 16'hFFFF);
        do_read(16'hB042, 32'h0521, "R6 enable mask");
        do_write(16'hB042, 16'h0000);
        sci_is(1'b0, "R7 sci low with enable cleared");

        @(posedge clk); #1 pwrbtn_evt = 1'b1;
        @(posedge clk); #1 pwrbtn_evt = 1'b0;
        do_read(16'hB040, 32'h0100, "R8 power button status");
        sci_is(1'b0, "R7 status without enable");
        do_write(16'hB042, 16'h0100);
        sci_is(1'b1, "R7 power button enabled");

        do_write(16'hB040, 16'h0000);
        do_read(16'hB040, 32'h0100, "R5 write zero keeps status");
        do_write(16'hB040, 16'h0400);
        do_read(16'hB040, 32'h0100, "R5 other bit clear keeps status");
        do_write(16'hB040, 16'h0100);
        do_read(16'hB040, 32'h0, "R5 write one clears");
        sci_is(1'b0, "R7 sci low after clear");

        @(posedge clk); #1 rtc_evt = 1'b1;
        @(posedge clk); #1 rtc_evt = 1'b0; gbl_req = 1'b1;
        @(posedge clk); #1 gbl_req = 1'b0;
        do_read(16'hB040, 32'h0420, "R8 rtc and global lock status");
        sci_is(1'b0, "R7 other enables do not fire");
        do_write(16'hB042, 16'h0400);
        sci_is(1'b1, "R7 rtc enabled");
        do_write(16'hB040, 16'h0400);
        sci_is(1'b0, "R7 global lock pending but disabled");
        do_write(16'hB042, 16'h0020);
        sci_is(1'b1, "R7 global lock enabled");
        do_write(16'hB040, 16'h0020);
        sci_is(1'b0, "R7 global lock cleared");

        @(posedge clk); #1;
        io_addr = 16'hB040; io_wdata = 16'h0100; io_wr = 1'b1; pwrbtn_evt = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0; pwrbtn_evt = 1'b0;
        do_read(16'hB040, 32'h0100, "R5 set wins over clear");
        do_write(16'hB040, 16'h0100);

        do_write(16'hB102, 16'h0001);
        do_read(16'hB042, 32'h0020, "R2 write outside window ignored");
        cfg_win_en = 1'b0;
        do_write(16'hB042, 16'h0400);
        cfg_win_en = 1'b1;
        do_read(16'hB042, 32'h0020, "R2 write with window disabled ignored");

        cfg_base_blk = 10'h100;
        read_none(16'hB042, "R3 old base no longer decoded");
        do_read(16'h4002, 32'h0020, "R3 enable at new base");
        do_read(16'h4004, 32'hA5C3, "R3 control kept at new base");
        do_read(16'h403F, 32'h0, "R3 top of window decoded");

        do_write(16'h4008, 16'h1234);
        do_read(16'h4008, 32'h0, "R9 timer write ignored");
        ticks(127);
        do_read(16'h4008, 32'h7F, "R9 timer count");
        do_read(16'h4008, 32'h7F, "R9 timer holds without tick");
        do_read(16'h4000, 32'h0, "R10 no flag before top bit change");
        ticks(1);
        do_read(16'h4000, 32'h0001, "R10 top bit rise sets flag");
        do_write(16'h4002, 16'h0001);
        sci_is(1'b1, "R7 timer enabled");
        do_write(16'h4000, 16'h0001);
        sci_is(1'b0, "R7 timer flag cleared");
        ticks(128);
        do_read(16'h4008, 32'h0, "R9 timer wraps");
        do_read(16'h4000, 32'h0001, "R10 top bit fall sets flag");
        sci_is(1'b1, "R7 timer flag after fall");

        repeat (2) @(posedge clk);
        check("R4 all responses seen", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule